// File: doc/BRIEF.md
# Auxiliary Pointer Indirect Address Unit

This unit keeps a bank of extended pointer registers, eight general auxiliary pointers and one coefficient pointer. Each pointer has a 7-bit page field above a 16-bit offset field. On every access request it forms an effective address from the selected pointer and applies a pointer modification chosen by a 3-bit mode code. Depending on the mode, the pointer is left alone, stepped by the operand size, offset by a signed constant before or without an update, or offset by one of two index inputs with or without a post-update.

A second lane can be enabled for dual accesses. It reads a second pointer under its own mode code and updates it in the same clock as the first. Both lanes share the constant, the index select and the operand size. For I/O-space requests the unit drives only the 16-bit offset and zeroes the page bits. It flags a fault when the pointer used for the request has a nonzero page. A load port writes a whole 23-bit pointer value so that software can set up the pointers. Addresses, valid flags and the fault flag are registered and appear one clock after the request.

Top module: `ptr_addr_unit`

## Requirements
- R1: A synchronous active-high reset clears every pointer to zero and drives `vld_a`, `vld_b`, `io_fault`, `addr_a` and `addr_b` low.
- R2: When `ld_en` is high, pointer `ld_sel` (0 to 7 auxiliary, 8 coefficient, larger values ignored) takes `ld_val` at the clock edge. If an access update targets the same pointer in that cycle, the load takes priority.
- R3: Mode 0 (and reserved mode 7) outputs the pointer as the address and leaves the pointer unchanged. Results appear one clock after the request, with `vld_a` high.
- R4: Mode 1 (post-increment) and mode 2 (post-decrement) output the old pointer and then step the offset by 1 when `acc_long` is 0 and by 2 when it is 1.
- R5: Mode 3 outputs the offset plus the constant `acc_k` and leaves the pointer unchanged.
- R6: Mode 4 adds `acc_k` to the pointer first, outputs the updated value and keeps it. For example, offset 0x0400 with +2 gives address 0x0402 and pointer 0x0402.
- R7: Mode 5 outputs the old pointer and then adds the selected index to the offset. The index is `t0` when `acc_tsel` is 0 and `t1` when it is 1.
- R8: Mode 6 outputs the offset plus the selected index and leaves the pointer unchanged.
- R9: All offset arithmetic wraps modulo 2^16. The page field (bits 22:16) of a pointer and of its address is never changed by a modification.
- R10: With `dual_en` and `acc_en` both high, lane B forms `addr_b` from pointer `dual_sel` under `dual_mode` and updates it in the same cycle as lane A. `vld_b` is high only for such requests.
- R11: If both lanes select the same pointer, only lane A's modification is applied, and lane B's is discarded.
- R12: When `acc_io` is high, the address outputs carry zero in bits 22:16 and the offset part of the effective address below. `io_fault` rises if a pointer used in that request has a nonzero page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 4 | Pointer index to load |
| ld_val | input | 23 | Page and offset value to load |
| acc_en | input | 1 | Access request |
| acc_sel | input | 4 | Lane A pointer index |
| acc_mode | input | 3 | Lane A modification code |
| acc_long | input | 1 | 1 for a 32-bit operand, 0 for 16-bit |
| acc_io | input | 1 | Request targets I/O space |
| acc_k | input | 16 | Signed constant offset |
| acc_tsel | input | 1 | Index select, 0 for t0, 1 for t1 |
| t0 | input | 16 | Index register 0 |
| t1 | input | 16 | Index register 1 |
| dual_en | input | 1 | Enable lane B |
| dual_sel | input | 4 | Lane B pointer index |
| dual_mode | input | 3 | Lane B modification code |
| addr_a | output | 23 | Lane A effective address |
| addr_b | output | 23 | Lane B effective address |
| vld_a | output | 1 | Lane A address valid |
| vld_b | output | 1 | Lane B address valid |
| io_fault | output | 1 | I/O request through a pointer with a nonzero page |

## Verification
The bench targets several boundary cases:
- Offset wrap at 0x0000 and 0xFFFF. A carry that leaked into the page field would show up as a changed page on the next plain read.
- Pre-modify against offset mode. Swapping their address selection would give the wrong address or leave a stale pointer.
- A dual request with both lanes on one pointer. Applying lane B's update would leave the pointer decremented instead of incremented.
- A load and an update to the same pointer in one cycle. The value the next plain access returns shows which one won.
- I/O requests through a paged pointer. A page that leaked onto the address, or a missing fault flag, is reported.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_POSTDEC = 3'd2,
    AM_OFFSET  = 3'd3,
    AM_PREMOD  = 3'd4,
    AM_POSTIDX = 3'd5,
    AM_IDXOFF  = 3'd6,
    AM_RSVD    = 3'd7
  } amode_e;
endpackage

// File: rtl/pau_lane.sv
// Combinational address and next-pointer generation for one lane.
module pau_lane
  import pau_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 16,
  localparam int AW    = PAGE_W + OFS_W
) (
  input  logic [AW-1:0]    ptr_i,
  input  amode_e           mode_i,
  input  logic             long_i,
  input  logic [OFS_W-1:0] k_i,
  input  logic [OFS_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    nxt_o,
  output logic             upd_o
);
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs, step, sum_k, sum_t, eff, nxt;

  always_comb begin
    page  = ptr_i[AW-1:OFS_W];
    ofs   = ptr_i[OFS_W-1:0];
    step  = long_i ? OFS_W'(2) : OFS_W'(1);
    sum_k = ofs + k_i;
    sum_t = ofs + idx_i;
    eff   = ofs;
    nxt   = ofs;
    upd_o = 1'b0;
    unique case (mode_i)
      AM_POSTINC: begin nxt = ofs + step; upd_o = 1'b1; end
      AM_POSTDEC: begin nxt = ofs - step; upd_o = 1'b1; end
      AM_OFFSET:  eff = sum_k;
      AM_PREMOD:  begin eff = sum_k; nxt = sum_k; upd_o = 1'b1; end
      AM_POSTIDX: begin nxt = sum_t; upd_o = 1'b1; end
      AM_IDXOFF:  eff = sum_t;
      default:    ;
    endcase
    addr_o = {page, eff};
    nxt_o  = {page, nxt};
  end
endmodule

// File: rtl/pau_ptr_bank.sv
// Pointer register file: load port has priority over lane A, lane A over lane B.
module pau_ptr_bank #(
  parameter int NPTR   = 9,
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 16,
  parameter int SEL_W  = 4,
  localparam int AW    = PAGE_W + OFS_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_en,
  input  logic [SEL_W-1:0]          ld_sel,
  input  logic [AW-1:0]             ld_val,
  input  logic                      wa_en,
  input  logic [SEL_W-1:0]          wa_sel,
  input  logic [AW-1:0]             wa_val,
  input  logic                      wb_en,
  input  logic [SEL_W-1:0]          wb_sel,
  input  logic [AW-1:0]             wb_val,
  output logic [NPTR-1:0][AW-1:0]   ptrs_o
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic ld_hit, wa_hit, wb_hit;
    assign ld_hit = ld_en && (int'(ld_sel) == g);
    assign wa_hit = wa_en && (int'(wa_sel) == g);
    assign wb_hit = wb_en && (int'(wb_sel) == g);

    always_ff @(posedge clk) begin
      if (rst)         ptrs_o[g] <= '0;
      else if (ld_hit) ptrs_o[g] <= ld_val;
      else if (wa_hit) ptrs_o[g] <= wa_val;
      else if (wb_hit) ptrs_o[g] <= wb_val;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ld_hit)) |-> ptrs_o[g] == $past(ld_val));

    assert_page_kept_R9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(!ld_hit && (wa_hit || wb_hit)))
        |-> ptrs_o[g][AW-1:OFS_W] == $past(ptrs_o[g][AW-1:OFS_W]));
  end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import pau_pkg::*;
#(
  parameter int N_AUX  = 8,
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 16,
  localparam int NPTR  = N_AUX + 1,
  localparam int SEL_W = $clog2(NPTR),
  localparam int AW    = PAGE_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [AW-1:0]    ld_val,
  input  logic             acc_en,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [2:0]       acc_mode,
  input  logic             acc_long,
  input  logic             acc_io,
  input  logic [OFS_W-1:0] acc_k,
  input  logic             acc_tsel,
  input  logic [OFS_W-1:0] t0,
  input  logic [OFS_W-1:0] t1,
  input  logic             dual_en,
  input  logic [SEL_W-1:0] dual_sel,
  input  logic [2:0]       dual_mode,
  output logic [AW-1:0]    addr_a,
  output logic [AW-1:0]    addr_b,
  output logic             vld_a,
  output logic             vld_b,
  output logic             io_fault
);
  logic [NPTR-1:0][AW-1:0] ptrs;
  logic [SEL_W-1:0] l_sel  [2];
  logic [2:0]       l_mode [2];
  logic [AW-1:0]    l_ptr  [2];
  logic [AW-1:0]    l_addr [2];
  logic [AW-1:0]    l_nxt  [2];
  logic             l_upd  [2];
  logic [OFS_W-1:0] idx;
  logic             wa_en, wb_en;

  assign l_sel[0]  = acc_sel;
  assign l_sel[1]  = dual_sel;
  assign l_mode[0] = acc_mode;
  assign l_mode[1] = dual_mode;
  assign idx       = acc_tsel ? t1 : t0;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign l_ptr[l] = (int'(l_sel[l]) < NPTR) ? ptrs[l_sel[l]] : '0;
    pau_lane #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_lane (
      .ptr_i  (l_ptr[l]),
      .mode_i (amode_e'(l_mode[l])),
      .long_i (acc_long),
      .k_i    (acc_k),
      .idx_i  (idx),
      .addr_o (l_addr[l]),
      .nxt_o  (l_nxt[l]),
      .upd_o  (l_upd[l])
    );
  end

  assign wa_en = acc_en && l_upd[0] && (int'(acc_sel) < NPTR);
  assign wb_en = acc_en && dual_en && l_upd[1] && (int'(dual_sel) < NPTR)
                 && (dual_sel != acc_sel);

  pau_ptr_bank #(.NPTR(NPTR), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ld_en),
    .ld_sel (ld_sel),
    .ld_val (ld_val),
    .wa_en  (wa_en),
    .wa_sel (acc_sel),
    .wa_val (l_nxt[0]),
    .wb_en  (wb_en),
    .wb_sel (dual_sel),
    .wb_val (l_nxt[1]),
    .ptrs_o (ptrs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_a   <= '0;
      addr_b   <= '0;
      vld_a    <= 1'b0;
      vld_b    <= 1'b0;
      io_fault <= 1'b0;
    end else begin
      addr_a   <= acc_io ? {{PAGE_W{1'b0}}, l_addr[0][OFS_W-1:0]} : l_addr[0];
      addr_b   <= acc_io ? {{PAGE_W{1'b0}}, l_addr[1][OFS_W-1:0]} : l_addr[1];
      vld_a    <= acc_en;
      vld_b    <= acc_en && dual_en;
      io_fault <= acc_en && acc_io &&
                  ((|l_ptr[0][AW-1:OFS_W]) || (dual_en && (|l_ptr[1][AW-1:OFS_W])));
    end
  end

  assert_io_page_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en && acc_io))
      |-> (addr_a[AW-1:OFS_W] == '0 && (!vld_b || addr_b[AW-1:OFS_W] == '0)));

  assert_vld_b_dual_R10: assert property (@(posedge clk) disable iff (rst)
    vld_b |-> (vld_a && $past(dual_en)));

  assert_postinc_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en && acc_mode == 3'd1 && int'(acc_sel) < NPTR
                          && !(ld_en && ld_sel == acc_sel)))
      |-> ((ptrs[$past(acc_sel)][OFS_W-1:0] - $past(l_addr[0][OFS_W-1:0]))
           == ($past(acc_long) ? OFS_W'(2) : OFS_W'(1))));
endmodule

// File: tb/test_ptr_addr_unit.sv
module test_ptr_addr_unit;
  logic clk = 1'b0;
  logic rst;
  logic ld_en; logic [3:0] ld_sel; logic [22:0] ld_val;
  logic acc_en; logic [3:0] acc_sel; logic [2:0] acc_mode;
  logic acc_long, acc_io, acc_tsel; logic [15:0] acc_k, t0, t1;
  logic dual_en; logic [3:0] dual_sel; logic [2:0] dual_mode;
  logic [22:0] addr_a, addr_b; logic vld_a, vld_b, io_fault;

  int n_run = 0, n_fail = 0;
  bit [22:0] mp [9];
  bit done = 0;

  always #10 clk = ~clk;

  ptr_addr_unit i_ptr_addr_unit (.*);

  task automatic idle();
    ld_en = 0; ld_sel = 0; ld_val = 0; acc_en = 0; acc_sel = 0; acc_mode = 0;
    acc_long = 0; acc_io = 0; acc_tsel = 0; acc_k = 0;
    dual_en = 0; dual_sel = 0; dual_mode = 0;
  endtask

  function automatic void calc(input int m, input bit [22:0] p,
                               output bit [22:0] e, output bit [22:0] n);
    bit [15:0] o = p[15:0];
    bit [15:0] t = acc_tsel ? t1 : t0;
    bit [15:0] s = acc_long ? 16'd2 : 16'd1;
    e = p; n = p;
    case (m)
      1: n[15:0] = o + s;
      2: n[15:0] = o - s;
      3: e[15:0] = o + acc_k;
      4: begin n[15:0] = o + acc_k; e = n; end
      5: n[15:0] = o + t;
      6: e[15:0] = o + t;
      default: ;
    endcase
  endfunction

  task automatic tick(input string req);
    bit [22:0] pa, pb, ea, eb, na, nb;
    bit xva, xvb, xf, ok;
    pa = (acc_sel < 9) ? mp[acc_sel] : 23'd0;
    pb = (dual_sel < 9) ? mp[dual_sel] : 23'd0;
    calc(int'(acc_mode), pa, ea, na);
    calc(int'(dual_mode), pb, eb, nb);
    if (acc_io) begin ea = {7'd0, ea[15:0]}; eb = {7'd0, eb[15:0]}; end
    xva = acc_en; xvb = acc_en && dual_en;
    xf = acc_en && acc_io && (pa[22:16] != 0 || (dual_en && pb[22:16] != 0));
    @(posedge clk); #1;
    ok = (vld_a == xva) && (vld_b == xvb) && (io_fault == xf)
         && (!xva || addr_a == ea) && (!xvb || addr_b == eb);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got va=%0b vb=%0b f=%0b a=%h b=%h, expected va=%0b vb=%0b f=%0b a=%h b=%h",
               req, vld_a, vld_b, io_fault, addr_a, addr_b, xva, xvb, xf, ea, eb);
    end
    if (acc_en && acc_sel < 9) mp[acc_sel] = na;
    if (acc_en && dual_en && dual_sel < 9 && dual_sel != acc_sel) mp[dual_sel] = nb;
    if (ld_en && ld_sel < 9) mp[ld_sel] = ld_val;
    @(negedge clk);
    idle();
  endtask

  task automatic load(input int s, input bit [22:0] v);
    ld_en = 1; ld_sel = 4'(s); ld_val = v; tick("R2 load");
  endtask

  task automatic acc(input int s, input int m, input bit lg, input string req);
    acc_en = 1; acc_sel = 4'(s); acc_mode = 3'(m); acc_long = lg; tick(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); t0 = 16'h0020; t1 = 16'hFFF0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    n_run++;
    if (vld_a || vld_b || io_fault || addr_a != 0 || addr_b != 0) begin
      n_fail++;
      $display("FAIL R1: got va=%0b vb=%0b f=%0b a=%h b=%h, expected all zero",
               vld_a, vld_b, io_fault, addr_a, addr_b);
    end
    for (int i = 0; i < 9; i++) acc(i, 0, 0, "R1 reset pointer zero");
    // R2 / R3 load and plain
    load(2, 23'h050100);
    acc(2, 0, 0, "R3 plain");
    acc(2, 7, 0, "R3 reserved code as plain");
    acc(2, 0, 0, "R3 unchanged");
    // R4 steps
    acc(2, 1, 0, "R4 postinc short"); acc(2, 0, 0, "R4 after postinc short");
    acc(2, 1, 1, "R4 postinc long");  acc(2, 0, 0, "R4 after postinc long");
    acc(2, 2, 1, "R4 postdec long");  acc(2, 2, 0, "R4 postdec short");
    acc(2, 0, 0, "R4 after postdec");
    // R9 wrap
    load(5, 23'h030000);
    acc(5, 2, 0, "R9 wrap down"); acc(5, 0, 0, "R9 page kept after wrap down");
    acc(5, 1, 0, "R9 wrap up");   acc(5, 0, 0, "R9 page kept after wrap up");
    // R6 / R5 on coefficient pointer
    load(8, 23'h000400);
    acc_k = 16'd2; acc(8, 4, 0, "R6 premod");
    acc(8, 0, 0, "R6 pointer updated");
    acc_k = 16'hFFFF; acc(8, 3, 0, "R5 offset");
    acc(8, 0, 0, "R5 pointer unchanged");
    // R7 / R8 index modes
    load(1, 23'h010010);
    acc_tsel = 0; acc(1, 5, 0, "R7 postidx t0");
    acc(1, 0, 0, "R7 after postidx");
    acc_tsel = 1; acc(1, 6, 0, "R8 idxoff t1");
    acc(1, 0, 0, "R8 pointer unchanged");
    acc_tsel = 1; acc(1, 5, 0, "R7 postidx t1 wrap");
    acc(1, 0, 0, "R7 after postidx t1");
    // R10 dual
    load(2, 23'h000100); load(3, 23'h000300);
    dual_en = 1; dual_sel = 3; dual_mode = 2; acc(2, 1, 0, "R10 dual inc/dec");
    dual_en = 1; dual_sel = 3; dual_mode = 0; acc(2, 0, 0, "R10 dual after update");
    dual_en = 1; dual_sel = 4; dual_mode = 0; tick("R10 no vld_b without acc_en");
    // R11 conflict
    load(4, 23'h000050);
    dual_en = 1; dual_sel = 4; dual_mode = 2; acc(4, 1, 0, "R11 same pointer both lanes");
    acc(4, 0, 0, "R11 only lane A applied");
    load(4, 23'h000050);
    dual_en = 1; dual_sel = 4; dual_mode = 1; acc(4, 0, 0, "R11 lane B discarded");
    acc(4, 0, 0, "R11 pointer unchanged");
    // R2 load priority
    load(6, 23'h001000);
    ld_en = 1; ld_sel = 6; ld_val = 23'h7F1234; acc(6, 1, 0, "R2 load with update");
    acc(6, 0, 0, "R2 load wins");
    // R12 io
    load(7, 23'h020777);
    acc_io = 1; acc(7, 0, 0, "R12 io paged pointer");
    acc_io = 1; acc_k = 16'h0010; acc(0, 3, 0, "R12 io page zero");
    acc_io = 1; dual_en = 1; dual_sel = 7; dual_mode = 0; acc(0, 0, 0, "R12 io dual fault");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule